// File: doc/BRIEF.md
# Low-Power Wakeup Decision Logic

This block sits beside a processor core and decides the cycle in which the core leaves a low-power state. When software enters a low-power state, the block records three things: how the state was entered (a wait-for-interrupt or a wait-for-event instruction), how deep the state is, and which interrupt lines were already pending. While the core is asleep, it watches the interrupt pending lines, the event lines and a set of deep-state wake sources. In the first cycle that meets the wake rule for the recorded mode, it emits a one-cycle wake pulse.

Two flags travel with the wake pulse. The first says whether the core must also take an interrupt. The second says whether the core must restart through its reset sequence instead of resuming. Sticky flags record whether the core has entered stop, stop2 or standby, and software clears each one by writing a one to it.

Wake pins and the radio busy line are asynchronous. Each passes through a two-flop synchronizer before edge detection. Every other input is assumed to be synchronous to `clk`.

Top module: `lowpower_wake`

## Requirements
- R1: While `rstN` is low and in the first cycle after reset, `wakePulse`, `takeIrq`, `restartReq` and all three sticky flags are 0, and the block is in the run state.
- R2: An interrupt line i qualifies when `irqPending[i]` and `irqEnable[i]` are both 1 and its priority field `irqPrio[i*PRIO_W +: PRIO_W]` is numerically greater than `prioThreshold`. In a shallow state (`enterDepth` 0 = sleep, 1 = stop, 2 = stop2; codes 5 to 7 behave as sleep) entered with `enterByEvent` = 0, a qualifying line wakes the core with `takeIrq` = 1. A disabled line or a line at or below the threshold does not wake the core.
- R3: In a shallow state entered with `enterByEvent` = 1, any bit of `eventIn` that is high wakes the core. `takeIrq` then shows whether some line qualifies in that cycle.
- R4: In a shallow wait-for-event state with `sevOnPend` = 0, a newly pending disabled line does not wake the core. A qualifying line wakes it with `takeIrq` = 1.
- R5: In a shallow wait-for-event state with `sevOnPend` = 1, a 0-to-1 change on any pending line while asleep wakes the core, even if the line is disabled. `takeIrq` is 1 only if some line qualifies. A line that was already pending when the state was entered does not wake the core.
- R6: In standby (`enterDepth` = 3) and shutdown (4), interrupts and `eventIn` are ignored. Each of the following wakes the core with `restartReq` = 1 and `takeIrq` = 0: `extRstReq`, `wdogRstReq`, `radioIrq`, `pvdEvent` and `rtcTamperEvent`.
- R7: `radioEvent` wakes the core from standby only and is ignored in shutdown.
- R8: In standby and shutdown, an enabled wake pin wakes the core on its rising edge when `wakePinPol[p]` = 0, or on its falling edge when `wakePinPol[p]` = 1. Either edge of `radioBusy` also wakes the core. A pin change driven before clock edge k gives a `wakePulse` that is visible after edge k+2. Pins with `wakePinEn[p]` = 0 are ignored.
- R9: Entering depth 1, 2 or 3 sets `flagStop`, `flagStop2` or `flagStandby` respectively. Each flag stays set across wakeups until the matching bit of `flagClear` (bit 0 stop, bit 1 stop2, bit 2 standby) is 1. A clear wins over a set in the same cycle.
- R10: `enterReq` is accepted in the run state only. The state is entered at the next edge, and `enterReq` is ignored while asleep. The wake pulse is registered and appears the cycle after the wake condition is sampled. It lasts exactly one cycle, after which the block is back in the run state, where wake sources have no effect. `takeIrq` and `restartReq` are 0 whenever `wakePulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enterReq | input | 1 | Request to enter a low-power state |
| enterByEvent | input | 1 | 1 = wait-for-event entry, 0 = wait-for-interrupt entry |
| enterDepth | input | 3 | 0 sleep, 1 stop, 2 stop2, 3 standby, 4 shutdown |
| irqPending | input | NUM_IRQ | Interrupt pending lines |
| irqEnable | input | NUM_IRQ | Per-line interrupt enables |
| irqPrio | input | NUM_IRQ*PRIO_W | Packed per-line priorities, line i at bits i*PRIO_W |
| prioThreshold | input | PRIO_W | Current priority threshold |
| sevOnPend | input | 1 | A new pending edge counts as an event |
| eventIn | input | NUM_EVT | Event lines |
| extRstReq | input | 1 | External reset wake source |
| wdogRstReq | input | 1 | Watchdog reset wake source |
| radioIrq | input | 1 | Radio interrupt wake source |
| pvdEvent | input | 1 | Voltage-detector wake source |
| radioBusy | input | 1 | Asynchronous radio busy line, both edges wake |
| rtcTamperEvent | input | 1 | Real-time-clock or tamper wake source |
| radioEvent | input | 1 | Radio event, standby only |
| wakePin | input | NUM_PIN | Asynchronous wake pins |
| wakePinEn | input | NUM_PIN | Per-pin enable |
| wakePinPol | input | NUM_PIN | Per-pin edge select, 1 = falling |
| flagClear | input | 3 | Write-one-to-clear for stop, stop2, standby flags |
| wakePulse | output | 1 | One-cycle wakeup pulse |
| takeIrq | output | 1 | Core must take an interrupt, valid with wakePulse |
| restartReq | output | 1 | Restart as from reset, valid with wakePulse |
| flagStop | output | 1 | Sticky stop-entered flag |
| flagStop2 | output | 1 | Sticky stop2-entered flag |
| flagStandby | output | 1 | Sticky standby-entered flag |

## Verification
A wrongly captured entry mode or depth shows at the ports in the first wake cycle. The pulse comes too early or never arrives, or `takeIrq` and `restartReq` disagree with the rule for the recorded mode. A stale pending snapshot shows as a wake one cycle after entry under the send-event-on-pending rule. A corrupted synchronizer stage moves the wake pulse off its fixed two-edge latency, and a flag error appears one cycle after the entry or the clear. For these reasons the bench compares every output against its model on every clock and adds latency checks on the pin paths.

// File: rtl/lpw_pkg.sv
package lpw_pkg;

  typedef enum logic [2:0] {
    DEPTH_SLEEP    = 3'd0,
    DEPTH_STOP     = 3'd1,
    DEPTH_STOP2    = 3'd2,
    DEPTH_STANDBY  = 3'd3,
    DEPTH_SHUTDOWN = 3'd4
  } lpwDepth_e;

  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_SLEEP = 1'b1
  } lpwState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic enter;  // entry accepted this cycle
    logic fire;   // wake decided this cycle
  } lpwStrobe_t;

endpackage

// File: rtl/lpw_edge_sync.sv
module lpw_edge_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] riseOut,
  output logic [WIDTH-1:0] fallOut
);
  logic [WIDTH-1:0] stage1, stage2, stage3;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      stage2 <= '0;
      stage3 <= '0;
    end else begin
      stage1 <= asyncIn;
      stage2 <= stage1;
      stage3 <= stage2;
    end
  end

  assign riseOut = stage2 & ~stage3;
  assign fallOut = ~stage2 & stage3;
endmodule

// File: rtl/lpw_control.sv
module lpw_control
  import lpw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enterReq,
  input  logic       wakeCond,
  output lpwStrobe_t strobe,
  output logic       wakePulse,
  output logic       asleep
);
  lpwState_e state, stateNext;

  always_comb begin
    strobe.enter = (state == ST_RUN) && enterReq;
    strobe.fire  = (state == ST_SLEEP) && wakeCond;
    stateNext    = state;
    if (strobe.enter)     stateNext = ST_SLEEP;
    else if (strobe.fire) stateNext = ST_RUN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_RUN;
      wakePulse <= 1'b0;
    end else begin
      state     <= stateNext;
      wakePulse <= strobe.fire;
    end
  end

  assign asleep = (state == ST_SLEEP);
endmodule

// File: rtl/lpw_datapath.sv
module lpw_datapath
  import lpw_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 3,
  parameter int NUM_EVT = 2,
  parameter int NUM_PIN = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  lpwStrobe_t                strobe,
  input  logic                      enterByEvent,
  input  logic [2:0]                enterDepth,
  input  logic [NUM_IRQ-1:0]        irqPending,
  input  logic [NUM_IRQ-1:0]        irqEnable,
  input  logic [NUM_IRQ*PRIO_W-1:0] irqPrio,
  input  logic [PRIO_W-1:0]         prioThreshold,
  input  logic                      sevOnPend,
  input  logic [NUM_EVT-1:0]        eventIn,
  input  logic                      extRstReq,
  input  logic                      wdogRstReq,
  input  logic                      radioIrq,
  input  logic                      pvdEvent,
  input  logic                      radioBusy,
  input  logic                      rtcTamperEvent,
  input  logic                      radioEvent,
  input  logic [NUM_PIN-1:0]        wakePin,
  input  logic [NUM_PIN-1:0]        wakePinEn,
  input  logic [NUM_PIN-1:0]        wakePinPol,
  input  logic [2:0]                flagClear,
  output logic                      wakeCond,
  output logic                      takeIrq,
  output logic                      restartReq,
  output logic                      flagStop,
  output logic                      flagStop2,
  output logic                      flagStandby
);
  localparam int FLAG_N = 3;

  logic             modeByEvent;
  logic [2:0]       modeDepth;
  logic [NUM_IRQ-1:0] pendPrev;
  logic [NUM_IRQ-1:0] prioAbove;
  logic [NUM_PIN-1:0] pinRise, pinFall, pinHit;
  logic             busyRise, busyFall;
  logic             qualified, newPend, evtAny, isDeep, deepWake, shallowWake;
  logic [FLAG_N-1:0] flagReg, flagSet;

  // per-line priority compare
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_prio
    assign prioAbove[i] = irqPrio[i*PRIO_W +: PRIO_W] > prioThreshold;
  end

  lpw_edge_sync #(.WIDTH(NUM_PIN)) u_pinSync (
    .clk(clk), .rstN(rstN), .asyncIn(wakePin),
    .riseOut(pinRise), .fallOut(pinFall)
  );

  lpw_edge_sync #(.WIDTH(1)) u_busySync (
    .clk(clk), .rstN(rstN), .asyncIn(radioBusy),
    .riseOut(busyRise), .fallOut(busyFall)
  );

  assign pinHit    = wakePinEn & ((~wakePinPol & pinRise) | (wakePinPol & pinFall));
  assign qualified = |(irqPending & irqEnable & prioAbove);
  assign newPend   = |(irqPending & ~pendPrev);
  assign evtAny    = |eventIn;
  assign isDeep    = (modeDepth == DEPTH_STANDBY) || (modeDepth == DEPTH_SHUTDOWN);

  always_comb begin
    deepWake = extRstReq | wdogRstReq | radioIrq | pvdEvent | rtcTamperEvent
             | busyRise | busyFall | (|pinHit)
             | (radioEvent & (modeDepth == DEPTH_STANDBY));
    if (modeByEvent) shallowWake = evtAny | qualified | (sevOnPend & newPend);
    else             shallowWake = qualified;
    wakeCond = isDeep ? deepWake : shallowWake;
  end

  // mode capture, pending history, wake qualifiers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeByEvent <= 1'b0;
      modeDepth   <= DEPTH_SLEEP;
      pendPrev    <= '0;
      takeIrq     <= 1'b0;
      restartReq  <= 1'b0;
    end else begin
      pendPrev <= irqPending;
      if (strobe.enter) begin
        modeByEvent <= enterByEvent;
        modeDepth   <= enterDepth;
      end
      takeIrq    <= strobe.fire & ~isDeep & qualified;
      restartReq <= strobe.fire & isDeep;
    end
  end

  // sticky mode flags, clear wins
  assign flagSet[0] = strobe.enter && (enterDepth == DEPTH_STOP);
  assign flagSet[1] = strobe.enter && (enterDepth == DEPTH_STOP2);
  assign flagSet[2] = strobe.enter && (enterDepth == DEPTH_STANDBY);

  for (genvar f = 0; f < FLAG_N; f++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             flagReg[f] <= 1'b0;
      else if (flagClear[f]) flagReg[f] <= 1'b0;
      else if (flagSet[f])   flagReg[f] <= 1'b1;
    end
  end

  assign flagStop    = flagReg[0];
  assign flagStop2   = flagReg[1];
  assign flagStandby = flagReg[2];
endmodule

// File: rtl/lowpower_wake.sv
module lowpower_wake
  import lpw_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 3,
  parameter int NUM_EVT = 2,
  parameter int NUM_PIN = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      enterReq,
  input  logic                      enterByEvent,
  input  logic [2:0]                enterDepth,
  input  logic [NUM_IRQ-1:0]        irqPending,
  input  logic [NUM_IRQ-1:0]        irqEnable,
  input  logic [NUM_IRQ*PRIO_W-1:0] irqPrio,
  input  logic [PRIO_W-1:0]         prioThreshold,
  input  logic                      sevOnPend,
  input  logic [NUM_EVT-1:0]        eventIn,
  input  logic                      extRstReq,
  input  logic                      wdogRstReq,
  input  logic                      radioIrq,
  input  logic                      pvdEvent,
  input  logic                      radioBusy,
  input  logic                      rtcTamperEvent,
  input  logic                      radioEvent,
  input  logic [NUM_PIN-1:0]        wakePin,
  input  logic [NUM_PIN-1:0]        wakePinEn,
  input  logic [NUM_PIN-1:0]        wakePinPol,
  input  logic [2:0]                flagClear,
  output logic                      wakePulse,
  output logic                      takeIrq,
  output logic                      restartReq,
  output logic                      flagStop,
  output logic                      flagStop2,
  output logic                      flagStandby
);
  lpwStrobe_t strobe;
  logic       wakeCond;
  logic       asleep;

  lpw_control u_control (
    .clk(clk), .rstN(rstN), .enterReq(enterReq), .wakeCond(wakeCond),
    .strobe(strobe), .wakePulse(wakePulse), .asleep(asleep)
  );

  lpw_datapath #(
    .NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .NUM_EVT(NUM_EVT), .NUM_PIN(NUM_PIN)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .enterByEvent(enterByEvent), .enterDepth(enterDepth),
    .irqPending(irqPending), .irqEnable(irqEnable), .irqPrio(irqPrio),
    .prioThreshold(prioThreshold), .sevOnPend(sevOnPend), .eventIn(eventIn),
    .extRstReq(extRstReq), .wdogRstReq(wdogRstReq), .radioIrq(radioIrq),
    .pvdEvent(pvdEvent), .radioBusy(radioBusy), .rtcTamperEvent(rtcTamperEvent),
    .radioEvent(radioEvent), .wakePin(wakePin), .wakePinEn(wakePinEn),
    .wakePinPol(wakePinPol), .flagClear(flagClear),
    .wakeCond(wakeCond), .takeIrq(takeIrq), .restartReq(restartReq),
    .flagStop(flagStop), .flagStop2(flagStop2), .flagStandby(flagStandby)
  );
endmodule

// File: rtl/lpw_checker.sv
module lpw_checker (
  input logic       clk,
  input logic       rstN,
  input logic       enterReq,
  input logic [2:0] enterDepth,
  input logic [2:0] flagClear,
  input logic       asleep,
  input logic       wakePulse,
  input logic       takeIrq,
  input logic       restartReq,
  input logic       flagStop,
  input logic       flagStop2,
  input logic       flagStandby
);
  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse);

  assert_run_no_wake_R10: assert property (@(posedge clk) disable iff (!rstN)
    !asleep |=> !wakePulse);

  assert_enter_accept_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!asleep && enterReq) |=> asleep);

  assert_pulse_back_run_R10: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> !asleep);

  assert_tags_with_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    (takeIrq || restartReq) |-> wakePulse);

  assert_deep_no_take_R6: assert property (@(posedge clk) disable iff (!rstN)
    restartReq |-> !takeIrq);

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    flagClear[1] |=> !flagStop2);

  assert_clear_standby_R9: assert property (@(posedge clk) disable iff (!rstN)
    flagClear[2] |=> !flagStandby);

  assert_stop_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!asleep && enterReq && enterDepth == 3'd1 && !flagClear[0]) |=> flagStop);
endmodule

bind lowpower_wake lpw_checker u_lpwChecker (
  .clk(clk), .rstN(rstN), .enterReq(enterReq), .enterDepth(enterDepth),
  .flagClear(flagClear), .asleep(asleep), .wakePulse(wakePulse),
  .takeIrq(takeIrq), .restartReq(restartReq), .flagStop(flagStop),
  .flagStop2(flagStop2), .flagStandby(flagStandby)
);

// File: tb/test_lowpower_wake.sv
`timescale 1ns/1ps
module test_lowpower_wake;
  localparam int NI = 8, PW = 3, NE = 2, NP = 3;

  logic clk = 0, rstN = 0;
  logic enterReq = 0, enterByEvent = 0;
  logic [2:0] enterDepth = 0;
  logic [NI-1:0] irqPending = 0, irqEnable = 0;
  logic [NI*PW-1:0] irqPrio = 0;
  logic [PW-1:0] prioThreshold = 0;
  logic sevOnPend = 0;
  logic [NE-1:0] eventIn = 0;
  logic extRstReq = 0, wdogRstReq = 0, radioIrq = 0, pvdEvent = 0;
  logic radioBusy = 0, rtcTamperEvent = 0, radioEvent = 0;
  logic [NP-1:0] wakePin = 0, wakePinEn = 0, wakePinPol = 0;
  logic [2:0] flagClear = 0;
  logic wakePulse, takeIrq, restartReq, flagStop, flagStop2, flagStandby;

  lowpower_wake #(.NUM_IRQ(NI), .PRIO_W(PW), .NUM_EVT(NE), .NUM_PIN(NP)) i_lowpower_wake (
    .clk(clk), .rstN(rstN), .enterReq(enterReq), .enterByEvent(enterByEvent),
    .enterDepth(enterDepth), .irqPending(irqPending), .irqEnable(irqEnable),
    .irqPrio(irqPrio), .prioThreshold(prioThreshold), .sevOnPend(sevOnPend),
    .eventIn(eventIn), .extRstReq(extRstReq), .wdogRstReq(wdogRstReq),
    .radioIrq(radioIrq), .pvdEvent(pvdEvent), .radioBusy(radioBusy),
    .rtcTamperEvent(rtcTamperEvent), .radioEvent(radioEvent), .wakePin(wakePin),
    .wakePinEn(wakePinEn), .wakePinPol(wakePinPol), .flagClear(flagClear),
    .wakePulse(wakePulse), .takeIrq(takeIrq), .restartReq(restartReq),
    .flagStop(flagStop), .flagStop2(flagStop2), .flagStandby(flagStandby)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0, cycles = 0, wakeSeen = 0;
  bit finished = 0;
  string curReq = "R1";
  bit lastTake = 0, lastRestart = 0;

  // behavioural reference model
  bit mAsleep, mByEvt, mWake, mTake, mRestart;
  int mDepth;
  bit [2:0] mFlags;
  bit [NI-1:0] mPendPrev;
  bit [NP-1:0] pinHist[3];
  bit busyHist[3];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mAsleep = 0; mByEvt = 0; mDepth = 0; mWake = 0; mTake = 0; mRestart = 0;
      mFlags = 0; mPendPrev = 0;
      for (int k = 0; k < 3; k++) begin pinHist[k] = 0; busyHist[k] = 0; end
    end else begin
      bit qual, newp, pinEv, deep, cond, fire, enter;
      qual = 0; newp = 0; pinEv = 0;
      for (int i = 0; i < NI; i++) begin
        if (irqPending[i] && irqEnable[i] && (int'(irqPrio[i*PW +: PW]) > int'(prioThreshold)))
          qual = 1;
        if (irqPending[i] && !mPendPrev[i]) newp = 1;
      end
      for (int p = 0; p < NP; p++)
        if (wakePinEn[p] && (wakePinPol[p] ? (pinHist[2][p] && !pinHist[1][p])
                                           : (pinHist[1][p] && !pinHist[2][p]))) pinEv = 1;
      deep = (mDepth == 3) || (mDepth == 4);
      if (deep)
        cond = extRstReq || wdogRstReq || radioIrq || pvdEvent || rtcTamperEvent ||
               (busyHist[1] != busyHist[2]) || pinEv || (radioEvent && mDepth == 3);
      else if (mByEvt)
        cond = (eventIn != 0) || qual || (sevOnPend && newp);
      else
        cond = qual;
      fire = mAsleep && cond;
      enter = !mAsleep && enterReq;
      mWake = fire; mTake = fire && !deep && qual; mRestart = fire && deep;
      for (int f = 0; f < 3; f++)
        if (flagClear[f]) mFlags[f] = 0;
        else if (enter && int'(enterDepth) == f + 1) mFlags[f] = 1;
      if (enter) begin mAsleep = 1; mByEvt = enterByEvent; mDepth = int'(enterDepth); end
      else if (fire) mAsleep = 0;
      mPendPrev = irqPending;
      pinHist[2] = pinHist[1]; pinHist[1] = pinHist[0]; pinHist[0] = wakePin;
      busyHist[2] = busyHist[1]; busyHist[1] = busyHist[0]; busyHist[0] = radioBusy;
    end
  end

  // every-clock comparison
  always @(negedge clk) if (!finished) begin
    total++;
    if (wakePulse !== mWake || takeIrq !== mTake || restartReq !== mRestart ||
        {flagStandby, flagStop2, flagStop} !== mFlags) begin
      bad++;
      $display("FAIL %s cycle %0d: wake/take/restart/flags act=%b%b%b/%b exp=%b%b%b/%b",
               curReq, cycles, wakePulse, takeIrq, restartReq,
               {flagStandby, flagStop2, flagStop}, mWake, mTake, mRestart, mFlags);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (wakePulse) begin wakeSeen++; lastTake = takeIrq; lastRestart = restartReq; end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter(int depth, bit byEvt);
    enterDepth = depth[2:0]; enterByEvent = byEvt; enterReq = 1;
    step(1);
    enterReq = 0;
  endtask

  task automatic expectWakes(int base, int n, string req);
    chk(wakeSeen - base == n, req, wakeSeen - base, n);
  endtask

  task automatic finish();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    int base;
    for (int i = 0; i < NI; i++) irqPrio[i*PW +: PW] = i[PW-1:0];
    prioThreshold = 3'd2;
    step(3);
    // R1 reset state
    chk(wakePulse == 0 && {flagStandby, flagStop2, flagStop} == 0, "R1", int'(wakePulse), 0);
    rstN = 1;
    step(2);
    chk(!wakePulse && !takeIrq && !restartReq, "R1", int'(wakePulse), 0);

    // R2 wait-for-interrupt
    curReq = "R2"; base = wakeSeen;
    enter(0, 0); step(2);
    irqPending[1] = 1; irqEnable[1] = 1;   // priority 1, not above threshold 2
    irqPending[4] = 1;                     // disabled
    step(4);
    expectWakes(base, 0, "R2");
    irqEnable[4] = 1;
    step(4);
    expectWakes(base, 1, "R2");
    chk(lastTake == 1, "R2", int'(lastTake), 1);
    irqPending = 0; irqEnable = 0; step(2);

    // R10 ignored re-entry, single pulse, no wake in run
    curReq = "R10"; base = wakeSeen;
    enter(0, 1); step(1);
    enter(3, 0); step(2);
    eventIn[0] = 1; step(1); eventIn = 0; step(3);
    expectWakes(base, 1, "R10");
    chk(lastRestart == 0, "R10", int'(lastRestart), 0);
    eventIn[1] = 1; extRstReq = 1; step(1); eventIn = 0; extRstReq = 0; step(3);
    expectWakes(base, 1, "R10");

    // R3 event wake without qualifying line
    curReq = "R3"; base = wakeSeen;
    enter(0, 1); step(3);
    expectWakes(base, 0, "R3");
    eventIn[1] = 1; step(1); eventIn = 0; step(3);
    expectWakes(base, 1, "R3");
    chk(lastTake == 0, "R3", int'(lastTake), 0);

    // R4 wait-for-event, sevOnPend clear
    curReq = "R4"; base = wakeSeen;
    enter(2, 1); step(2);
    irqPending[5] = 1; step(4);
    expectWakes(base, 0, "R4");
    irqEnable[6] = 1; irqPending[6] = 1; step(4);
    expectWakes(base, 1, "R4");
    chk(lastTake == 1, "R4", int'(lastTake), 1);
    irqPending = 0; irqEnable = 0; step(2);

    // R5 wait-for-event, sevOnPend set
    curReq = "R5"; base = wakeSeen; sevOnPend = 1;
    irqPending[2] = 1; step(1);
    enter(0, 1); step(5);
    expectWakes(base, 0, "R5");
    irqPending[7] = 1; step(4);
    expectWakes(base, 1, "R5");
    chk(lastTake == 0, "R5", int'(lastTake), 0);
    irqPending[7] = 0; step(1);
    enter(1, 1); step(2);
    irqEnable[1] = 1; irqPending[1] = 1; step(4);
    expectWakes(base, 2, "R5");
    chk(lastTake == 0, "R5", int'(lastTake), 0);
    irqPending = 0; irqEnable = 0; sevOnPend = 0; step(2);

    // R9 sticky flags
    curReq = "R9";
    chk(flagStop == 1 && flagStop2 == 1 && flagStandby == 0, "R9",
        int'({flagStandby, flagStop2, flagStop}), 3);
    flagClear = 3'b011; step(1); flagClear = 0; step(1);
    enter(1, 1); step(1);
    chk(flagStop == 1 && flagStop2 == 0, "R9", int'({flagStop2, flagStop}), 1);
    eventIn[0] = 1; step(1); eventIn = 0; step(2);
    chk(flagStop == 1, "R9", int'(flagStop), 1);
    flagClear = 3'b010; enterDepth = 3'd2; enterByEvent = 1; enterReq = 1;
    step(1); enterReq = 0; flagClear = 0; step(1);
    chk(flagStop2 == 0, "R9", int'(flagStop2), 0);
    eventIn[0] = 1; step(1); eventIn = 0; step(2);

    // R6 deep wake sources
    curReq = "R6"; base = wakeSeen;
    enter(3, 0); step(1);
    chk(flagStandby == 1, "R9", int'(flagStandby), 1);
    irqEnable[5] = 1; irqPending[5] = 1; eventIn[0] = 1; step(4);
    eventIn = 0;
    expectWakes(base, 0, "R6");
    extRstReq = 1; step(1); extRstReq = 0; step(3);
    expectWakes(base, 1, "R6");
    chk(lastRestart == 1 && lastTake == 0, "R6", int'({lastRestart, lastTake}), 2);
    irqPending = 0; irqEnable = 0; step(1);
    enter(4, 0); step(1); wdogRstReq = 1; step(1); wdogRstReq = 0; step(2);
    enter(4, 0); step(1); radioIrq = 1; step(1); radioIrq = 0; step(2);
    enter(3, 0); step(1); pvdEvent = 1; step(1); pvdEvent = 0; step(2);
    enter(4, 0); step(1); rtcTamperEvent = 1; step(1); rtcTamperEvent = 0; step(2);
    expectWakes(base, 5, "R6");
    chk(lastRestart == 1, "R6", int'(lastRestart), 1);

    // R7 radio event in standby only
    curReq = "R7"; base = wakeSeen;
    enter(4, 0); step(1); radioEvent = 1; step(1); radioEvent = 0; step(3);
    expectWakes(base, 0, "R7");
    rtcTamperEvent = 1; step(1); rtcTamperEvent = 0; step(3);
    enter(3, 0); step(1); radioEvent = 1; step(1); radioEvent = 0; step(3);
    expectWakes(base, 2, "R7");

    // R8 wake pins and busy line
    curReq = "R8"; base = wakeSeen;
    wakePinEn = 3'b101; wakePinPol = 3'b100; wakePin[2] = 1; step(5);
    enter(3, 0); step(1);
    wakePin[1] = 1; step(5);
    expectWakes(base, 0, "R8");
    wakePin[0] = 1;
    step(2); chk(wakePulse == 0, "R8", int'(wakePulse), 0);
    step(1); chk(wakePulse == 1, "R8", int'(wakePulse), 1);
    step(2);
    enter(4, 0); step(1);
    wakePin[0] = 0; step(5);
    expectWakes(base, 1, "R8");
    wakePin[2] = 0;
    step(2); chk(wakePulse == 0, "R8", int'(wakePulse), 0);
    step(1); chk(wakePulse == 1, "R8", int'(wakePulse), 1);
    step(2);
    enter(3, 0); step(1); radioBusy = 1; step(5);
    enter(3, 0); step(1); radioBusy = 0; step(5);
    expectWakes(base, 4, "R8");
    step(3);
    finish();
  end

  initial begin
    wait (cycles > 5000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: act=%0d exp<=5000 cycles", cycles);
      finish();
    end
  end
endmodule